// File: doc/BRIEF.md
# Preemptive Fixed-Priority Bus Grant Controller

This block decides which of several requesters may drive a shared bus in each clock period. Each requester raises its own request line. The controller answers with one-hot grant lines, and at most one grant is high in any cycle. The lowest-numbered requester has the highest priority. A higher-priority requester can take the bus from the current owner at any time.

The controller is a Moore machine with two kinds of state, so the grants depend only on the state register. The first kind is the idle state (transition names: `IDLE_WAIT` stays idle, `IDLE_TO_OWN` grants). The second kind is one owner state per requester (`OWN_HOLD` keeps the grant, `OWN_RELEASE` returns to idle). With the default of four requesters there are five states: idle with grants 0000, and owner 0, 1, 2 and 3 with grants 0001, 0010, 0100 and 1000 (written `gnt[3:0]`).

Every change of owner passes through exactly one idle cycle. This happens whether the owner released the bus or was preempted. In the cycle after that idle cycle, the highest-priority request active at that moment is granted.

Top module: `bus_grant_ctrl`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) puts the controller in idle, and all grants are low after that edge.
- R2: At most one bit of `gnt` is high in any cycle.
- R3: In idle with at least one request high, the next edge grants the requester with the lowest index among the active ones (`gnt[i]` belongs to `req[i]`, and index 0 has the highest priority).
- R4: In idle with no request high, the controller stays idle and all grants stay low.
- R5: An owner keeps its grant while its own request stays high and no lower-index request is high. Requests with a higher index than the owner's have no effect on the grant.
- R6: When a request with a lower index than the current owner's rises, the next edge drops all grants (idle). The edge after that grants the highest-priority request active at that moment.
- R7: When the owner lowers its request, the next edge drops all grants (idle) for one cycle.
- R8: The grant never moves directly from one requester to another. A non-zero grant is followed either by the same grant or by all-zero.
- R9: Grants change only at clock edges, because they are decoded from the state register alone.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | NUM_REQ | Request lines; bit i belongs to requester i, and bit 0 has the highest priority |
| gnt | output | NUM_REQ | One-hot grant lines, registered; bit i grants requester i |

## Verification
The bench builds the controller with its default of four requesters. With that value all five states and every transition between them can be reached. The stimulus covers preemption at each priority level, lower-priority requests arriving while a higher one holds the bus, and an owner releasing the bus. It also covers a requester that withdraws during the idle gap and reset while a requester owns the bus. Expected grants follow the rule that idle always lies between two owners, so every owner change is observed as a zero cycle followed by the new winner.

// File: rtl/busarb_pkg.sv
package busarb_pkg;

    // Kind of state: idle, or some requester owns the bus.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_OWN  = 1'b1
    } phase_e;

endpackage

// File: rtl/prio_pick.sv
// Fixed-priority selector: the lowest set index wins.
module prio_pick #(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic [NUM_REQ-1:0] req,
    output logic               any,
    output logic [IDX_W-1:0]   idx
);

    always_comb begin
        idx = '0;
        // Walk from the lowest priority upward so the lowest index is the last write.
        for (int i = NUM_REQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end

    assign any = |req;

endmodule

// File: rtl/grant_fsm.sv
// Idle-gapped, preemptive owner state machine.
module grant_fsm
    import busarb_pkg::*;
#(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req,
    input  logic               pick_any,
    input  logic [IDX_W-1:0]   pick_idx,
    output phase_e             phase_q,
    output logic [IDX_W-1:0]   owner_q
);

    phase_e           phase_d;
    logic [IDX_W-1:0] owner_d;
    logic             own_req;
    logic             higher_req;

    // The owner's own request line, and whether a higher-priority request is active.
    assign own_req    = req[owner_q];
    assign higher_req = pick_any && (pick_idx < owner_q);

    // Next-state logic.
    always_comb begin
        phase_d = phase_q;
        owner_d = owner_q;
        unique case (phase_q)
            ST_IDLE: begin
                if (pick_any) begin          // IDLE_TO_OWN
                    phase_d = ST_OWN;
                    owner_d = pick_idx;
                end
                // otherwise IDLE_WAIT
            end
            ST_OWN: begin
                if (!own_req || higher_req) begin   // OWN_RELEASE (drop or preempt)
                    phase_d = ST_IDLE;
                end
                // otherwise OWN_HOLD
            end
            default: phase_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= ST_IDLE;
            owner_q <= '0;
        end else begin
            phase_q <= phase_d;
            owner_q <= owner_d;
        end
    end

    // R1: reset lands in idle
    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (phase_q == ST_IDLE));

    // R3: idle with requests grants the selector's winner
    p_idle_grant_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_IDLE && pick_any) |=>
            (phase_q == ST_OWN && owner_q == $past(pick_idx)));

    // R4: idle without requests stays idle
    p_idle_stay_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_IDLE && !pick_any) |=> (phase_q == ST_IDLE));

    // R5: owner holds while requesting with nothing higher
    p_owner_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_OWN && own_req && !higher_req) |=>
            (phase_q == ST_OWN && owner_q == $past(owner_q)));

    // R6: higher-priority request forces idle
    p_preempt_r6: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_OWN && higher_req) |=> (phase_q == ST_IDLE));

    // R7: owner release forces idle
    p_release_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_q == ST_OWN && !own_req) |=> (phase_q == ST_IDLE));

endmodule

// File: rtl/grant_dec.sv
// Decodes the state register into one-hot grant lines.
module grant_dec
    import busarb_pkg::*;
#(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  phase_e             phase_q,
    input  logic [IDX_W-1:0]   owner_q,
    output logic [NUM_REQ-1:0] gnt
);

    for (genvar g = 0; g < NUM_REQ; g++) begin : g_line
        assign gnt[g] = (phase_q == ST_OWN) && (owner_q == IDX_W'(g));
    end

    // R2: never more than one grant
    p_onehot_gnt_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R8: a grant either holds or returns to zero
    p_idle_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0) |=> (gnt == '0 || gnt == $past(gnt)));

endmodule

// File: rtl/bus_grant_ctrl.sv
module bus_grant_ctrl
    import busarb_pkg::*;
#(
    parameter int NUM_REQ = 4,
    localparam int IDX_W  = (NUM_REQ > 1) ? $clog2(NUM_REQ) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_REQ-1:0] req,
    output logic [NUM_REQ-1:0] gnt
);

    logic             pick_any;
    logic [IDX_W-1:0] pick_idx;
    phase_e           phase_q;
    logic [IDX_W-1:0] owner_q;

    prio_pick #(.NUM_REQ(NUM_REQ)) u_pick (
        .req (req),
        .any (pick_any),
        .idx (pick_idx)
    );

    grant_fsm #(.NUM_REQ(NUM_REQ)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req      (req),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .phase_q  (phase_q),
        .owner_q  (owner_q)
    );

    grant_dec #(.NUM_REQ(NUM_REQ)) u_dec (
        .clk     (clk),
        .rst     (rst),
        .phase_q (phase_q),
        .owner_q (owner_q),
        .gnt     (gnt)
    );

endmodule

// File: tb/tb_bus_grant_ctrl.sv
module tb_bus_grant_ctrl;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] req = 4'b0000;
    logic [3:0] gnt;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    bus_grant_ctrl #(.NUM_REQ(4)) dut (
        .clk (clk),
        .rst (rst),
        .req (req),
        .gnt (gnt)
    );

    // Each entry is {req applied before the edge, expected gnt after the edge}.
    localparam logic [7:0] VEC [0:16] = '{
        {4'b0000, 4'b0000},  // R4 idle stays idle
        {4'b1000, 4'b1000},  // R3 lone device 3 granted
        {4'b1000, 4'b1000},  // R5 hold
        {4'b1100, 4'b0000},  // R6 device 2 preempts -> idle
        {4'b1100, 4'b0100},  // R6 device 2 granted after gap
        {4'b0100, 4'b0100},  // R5 hold
        {4'b0101, 4'b0000},  // R6 device 0 preempts
        {4'b0101, 4'b0001},  // R3 device 0 wins
        {4'b1111, 4'b0001},  // R5 lower requests ignored
        {4'b1110, 4'b0000},  // R7 owner drops
        {4'b1110, 4'b0010},  // R3 device 1 highest
        {4'b0000, 4'b0000},  // R7 release
        {4'b0000, 4'b0000},  // R4
        {4'b0010, 4'b0010},  // R3
        {4'b1010, 4'b0010},  // R5 device 3 ignored
        {4'b1000, 4'b0000},  // R7 / R8 no direct hand-over
        {4'b0000, 4'b0000}   // R4 withdrawn during gap
    };

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: gnt actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic step(input logic [3:0] r, input logic [3:0] exp, input string tag);
        @(negedge clk);
        req = r;
        @(posedge clk);
        #1;
        check(tag, gnt, exp);
        // R2: never more than one grant
        checks++;
        if ($countones(gnt) > 1) begin
            failures++;
            $display("FAIL R2: gnt actual=%b expected=at most one bit", gnt);
        end
    endtask

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset idle", gnt, 4'b0000);
        @(negedge clk);
        rst = 1'b0;

        for (int i = 0; i < 17; i++) begin
            step(VEC[i][7:4], VEC[i][3:0], "R3-R8 vector");
        end

        // R1: reset while device 0 owns the bus
        step(4'b0001, 4'b0001, "R3 grant before reset");
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        #1;
        check("R1 reset drops owner", gnt, 4'b0000);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R3 grant after reset", gnt, 4'b0001);

        // R6: preempt and owner drop in the same cycle
        step(4'b0100, 4'b0000, "R7 owner 0 drops");
        step(4'b0100, 4'b0100, "R3 device 2 granted");
        step(4'b0001, 4'b0000, "R6 drop plus preempt");
        step(4'b0001, 4'b0001, "R6 device 0 after gap");

        // R9: grant stable between edges even when requests change
        @(negedge clk);
        req = 4'b0000;
        #2;
        check("R9 no change before edge", gnt, 4'b0001);
        @(posedge clk);
        #1;
        check("R7 released at edge", gnt, 4'b0000);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule